// File: doc/BRIEF.md
# Dual-Source Supply Switching Controller

This block decides whether the chip runs from its battery or from power rectified out of a magnetic field at the coil, and it produces the reset and wake signals that go with those decisions. It watches two already-filtered comparator flags: one says the coil voltage is above the field-on threshold, the other says it is below the field-off threshold. Neither flag changes the supply on its own. A change needs the flag held for a full, parameterised number of clock cycles, and each direction has its own count.

Each return from field to battery starts a reset pulse of fixed length on an open-drain-style output, so that the attached controller restarts cleanly. A second, internal active-low reset feeds the rest of the chip's digital logic. It follows that pulse, the power-on reset, and the external reset pin. A separate field-present flag with hysteresis reports field and gaps, and its rising edge serves as the wake signal.

Command bytes forwarded by the serial command decoder can turn automatic switching off, which pins the supply to battery, and turn it back on. Only the power-on reset restores automatic mode by itself. The supply decision uses the coil flags alone, so a switch to field supply works with no battery present.

Top module: `supply_sel_ctrl`

## Requirements
- R1: With automatic mode on and battery selected, `sel_field` goes high at the clock edge that samples `coil_above_on` high for the BFS_CYC-th time in a row. Any low sample restarts the count, so a shorter run leaves `sel_field` low.
- R2: With field selected, `sel_field` goes low at the edge that samples `coil_below_off` high for the FBS_CYC-th time in a row. A shorter run leaves it high.
- R3: Every fall of `sel_field`, whether caused by the timer or by a disable command, raises `rst_drive` at that same edge and holds it for exactly RST_CYC cycles. `core_rst_n` is low for that whole time.
- R4: After power-on reset, `sel_field` and `field_present` are low and automatic mode is on. `rst_drive` is high and `core_rst_n` low until the RST_CYC-th clock edge after release.
- R5: A low on `ext_rst_n` sampled at an edge drives `core_rst_n` low at that edge. `core_rst_n` returns high at the first edge that samples `ext_rst_n` high. The external reset changes neither `rst_drive`, nor `sel_field`, nor the automatic mode.
- R6: `field_present` goes low one cycle after `coil_below_off` is sampled high. It goes high one cycle after `coil_above_on` is sampled high while `coil_below_off` is low. Otherwise it holds its value, and the automatic mode does not affect it.
- R7: A command byte with bits [7:6]=11, bits [2:0]=111 and bit 3=0, presented with `cmd_valid`, turns automatic mode off. `sel_field` is low from that edge on, whatever the coil flags do.
- R8: The same pattern with bit 3=1 turns automatic mode back on. The on-delay count starts with the edge after the command.
- R9: Command bytes matching neither pattern leave the mode unchanged. The disabled state survives `ext_rst_n` and is cleared only by power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_por_n | input | 1 | Asynchronous active-low power-on reset |
| coil_above_on | input | 1 | Filtered flag: coil voltage above field-on threshold |
| coil_below_off | input | 1 | Filtered flag: coil voltage below field-off threshold |
| ext_rst_n | input | 1 | External reset pin level, active low |
| cmd_valid | input | 1 | Command byte strobe from serial decoder |
| cmd_byte | input | 8 | Command byte |
| sel_field | output | 1 | Supply select: 1 field, 0 battery |
| field_present | output | 1 | 1 field present, 0 gap or no field; rising edge wakes |
| rst_drive | output | 1 | 1 pulls the shared reset pin low |
| core_rst_n | output | 1 | Active-low reset for the chip's digital logic |

## Verification
A timer that is off by one shows up as a `sel_field` edge one cycle early or late relative to the first qualifying sample, so every switch is checked at its exact edge. A mode latch in the wrong state shows up only when coil activity follows: `sel_field` stays low during a long field-on run, or it rises when it should not. The bench therefore holds the field-on flag well past the delay after every mode command. A reset counter in the wrong state moves the falling edge of `rst_drive` within RST_CYC cycles of the trigger. A field flag with the wrong hysteresis shows on `field_present` on the very next cycle.

// File: rtl/pwr_sw_pkg.sv
package pwr_sw_pkg;

    typedef struct packed {
        logic sel_field;
        logic auto_mode;
        logic fld_flag;
    } ctl_state_t;

    typedef enum logic [1:0] {
        MCMD_NONE,
        MCMD_AUTO_OFF,
        MCMD_AUTO_ON
    } mode_cmd_e;

    // Mode command pattern: [7:6]=11, [2:0]=111, bit 3 selects on/off
    function automatic mode_cmd_e decode_mode_cmd(input logic [7:0] b);
        mode_cmd_e r;
        r = MCMD_NONE;
        if (b[7:6] == 2'b11 && b[2:0] == 3'b111) begin
            r = b[3] ? MCMD_AUTO_ON : MCMD_AUTO_OFF;
        end
        return r;
    endfunction

endpackage

// File: rtl/pwr_qual_timer.sv
module pwr_qual_timer #(
    parameter int LIMIT = 16,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    output logic expire
);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expire = qual && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!qual || expire) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pwr_rst_pulse.sv
module pwr_rst_pulse #(
    parameter int PULSE = 32,
    localparam int PW = $clog2(PULSE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic ext_rst_n,
    output logic rst_drive,
    output logic core_rst_n
);

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          drive;
        logic          core_n;
    } pulse_t;

    pulse_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (trigger) begin
            p_d.cnt = PW'(PULSE);
        end else if (p_q.cnt != '0) begin
            p_d.cnt = p_q.cnt - 1'b1;
        end
        p_d.drive  = (p_d.cnt != '0);
        p_d.core_n = ext_rst_n && !p_d.drive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.cnt    <= PW'(PULSE);
            p_q.drive  <= 1'b1;
            p_q.core_n <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign rst_drive  = p_q.drive;
    assign core_rst_n = p_q.core_n;

endmodule

// File: rtl/supply_sel_ctrl.sv
module supply_sel_ctrl
    import pwr_sw_pkg::*;
#(
    parameter int BFS_CYC = 5000,
    parameter int FBS_CYC = 1000,
    parameter int RST_CYC = 64
) (
    input  logic       clk,
    input  logic       rst_por_n,
    input  logic       coil_above_on,
    input  logic       coil_below_off,
    input  logic       ext_rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output logic       sel_field,
    output logic       field_present,
    output logic       rst_drive,
    output logic       core_rst_n
);

    localparam int NTMR = 2;

    ctl_state_t st_d, st_q;
    mode_cmd_e  mcmd;
    logic [NTMR-1:0] tmr_qual, tmr_exp;
    logic       fall_trig;
    logic       auto_mode_q;

    assign mcmd = cmd_valid ? decode_mode_cmd(cmd_byte) : MCMD_NONE;

    // index 0: battery->field qualifier, index 1: field->battery qualifier
    assign tmr_qual[0] = coil_above_on && st_q.auto_mode && !st_q.sel_field;
    assign tmr_qual[1] = coil_below_off && st_q.sel_field;

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        pwr_qual_timer #(
            .LIMIT(i == 0 ? BFS_CYC : FBS_CYC)
        ) u_tmr (
            .clk   (clk),
            .rst_n (rst_por_n),
            .qual  (tmr_qual[i]),
            .expire(tmr_exp[i])
        );
    end

    always_comb begin
        st_d = st_q;
        case (mcmd)
            MCMD_AUTO_OFF: st_d.auto_mode = 1'b0;
            MCMD_AUTO_ON:  st_d.auto_mode = 1'b1;
            default:       ;
        endcase
        if (!st_d.auto_mode) begin
            st_d.sel_field = 1'b0;
        end else if (tmr_exp[0]) begin
            st_d.sel_field = 1'b1;
        end else if (tmr_exp[1]) begin
            st_d.sel_field = 1'b0;
        end
        if (coil_below_off) begin
            st_d.fld_flag = 1'b0;
        end else if (coil_above_on) begin
            st_d.fld_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_por_n) begin
        if (!rst_por_n) begin
            st_q.sel_field <= 1'b0;
            st_q.auto_mode <= 1'b1;
            st_q.fld_flag  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_trig = st_q.sel_field && !st_d.sel_field;

    pwr_rst_pulse #(
        .PULSE(RST_CYC)
    ) u_rst (
        .clk       (clk),
        .rst_n     (rst_por_n),
        .trigger   (fall_trig),
        .ext_rst_n (ext_rst_n),
        .rst_drive (rst_drive),
        .core_rst_n(core_rst_n)
    );

    assign sel_field     = st_q.sel_field;
    assign field_present = st_q.fld_flag;
    assign auto_mode_q   = st_q.auto_mode;

endmodule

// File: rtl/supply_sel_chk.sv
module supply_sel_chk #(
    parameter int BFS_CYC = 5000,
    parameter int FBS_CYC = 1000
) (
    input logic clk,
    input logic rst_por_n,
    input logic coil_above_on,
    input logic coil_below_off,
    input logic ext_rst_n,
    input logic sel_field,
    input logic field_present,
    input logic rst_drive,
    input logic core_rst_n,
    input logic auto_mode
);

    int on_run, off_run;

    always_ff @(posedge clk or negedge rst_por_n) begin
        if (!rst_por_n) begin
            on_run  <= 0;
            off_run <= 0;
        end else begin
            if (!coil_above_on) on_run <= 0;
            else if (on_run < BFS_CYC) on_run <= on_run + 1;
            if (!coil_below_off) off_run <= 0;
            else if (off_run < FBS_CYC) off_run <= off_run + 1;
        end
    end

    a_r1_on_delay: assert property (@(posedge clk) disable iff (!rst_por_n)
        $rose(sel_field) |-> (on_run >= BFS_CYC));

    a_r2_off_delay: assert property (@(posedge clk) disable iff (!rst_por_n)
        $fell(sel_field) |-> ((off_run >= FBS_CYC) || !auto_mode));

    a_r3_fall_resets: assert property (@(posedge clk) disable iff (!rst_por_n)
        $fell(sel_field) |-> (rst_drive && !core_rst_n));

    a_r5_ext_reset: assert property (@(posedge clk) disable iff (!rst_por_n)
        !ext_rst_n |=> !core_rst_n);

    a_r6_gap_clears: assert property (@(posedge clk) disable iff (!rst_por_n)
        coil_below_off |=> !field_present);

    a_r6_field_sets: assert property (@(posedge clk) disable iff (!rst_por_n)
        (coil_above_on && !coil_below_off) |=> field_present);

    a_r7_disabled_battery: assert property (@(posedge clk) disable iff (!rst_por_n)
        !auto_mode |-> !sel_field);

endmodule

bind supply_sel_ctrl supply_sel_chk #(
    .BFS_CYC(BFS_CYC),
    .FBS_CYC(FBS_CYC)
) u_chk (
    .clk           (clk),
    .rst_por_n     (rst_por_n),
    .coil_above_on (coil_above_on),
    .coil_below_off(coil_below_off),
    .ext_rst_n     (ext_rst_n),
    .sel_field     (sel_field),
    .field_present (field_present),
    .rst_drive     (rst_drive),
    .core_rst_n    (core_rst_n),
    .auto_mode     (auto_mode_q)
);

// File: tb/supply_sel_ctrl_bench.sv
module supply_sel_ctrl_bench;

    localparam int BFS = 6;
    localparam int FBS = 4;
    localparam int RST = 5;

    // signal codes for the scoreboard
    localparam int S_SEL = 0;
    localparam int S_FP  = 1;
    localparam int S_DRV = 2;
    localparam int S_CRS = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_por_n = 1'b0;
    logic       coil_above_on = 1'b0;
    logic       coil_below_off = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       sel_field, field_present, rst_drive, core_rst_n;

    supply_sel_ctrl #(
        .BFS_CYC(BFS),
        .FBS_CYC(FBS),
        .RST_CYC(RST)
    ) u_supply_sel_ctrl (
        .clk           (clk),
        .rst_por_n     (rst_por_n),
        .coil_above_on (coil_above_on),
        .coil_below_off(coil_below_off),
        .ext_rst_n     (ext_rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_byte      (cmd_byte),
        .sel_field     (sel_field),
        .field_present (field_present),
        .rst_drive     (rst_drive),
        .core_rst_n    (core_rst_n)
    );

    int cyc;
    always @(posedge clk or negedge rst_por_n) begin
        if (!rst_por_n) cyc <= 0;
        else            cyc <= cyc + 1;
    end

    typedef struct {
        int   at;
        int   sig;
        logic val;
        int   req;
    } exp_t;

    exp_t sb_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic expect_at(input int at, input int sig, input logic val, input int req);
        int pos;
        exp_t e;
        pos = sb_q.size();
        for (int i = 0; i < sb_q.size(); i++) begin
            if (sb_q[i].at > at) begin
                pos = i;
                break;
            end
        end
        e.at = at; e.sig = sig; e.val = val; e.req = req;
        sb_q.insert(pos, e);
    endtask

    task automatic to_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    function automatic logic pick(input int s);
        case (s)
            S_SEL:   return sel_field;
            S_FP:    return field_present;
            S_DRV:   return rst_drive;
            default: return core_rst_n;
        endcase
    endfunction

    function automatic string sname(input int s);
        case (s)
            S_SEL:   return "sel_field";
            S_FP:    return "field_present";
            S_DRV:   return "rst_drive";
            default: return "core_rst_n";
        endcase
    endfunction

    // monitor: pops expectations due this cycle and compares
    always @(negedge clk) begin
        exp_t e;
        logic got;
        if (rst_por_n) begin
            while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
                e = sb_q.pop_front();
                got = pick(e.sig);
                n_chk++;
                if (e.at != cyc || got !== e.val) begin
                    n_fail++;
                    $display("FAIL R%0d %s cycle %0d (due %0d): got %b expected %b",
                             e.req, sname(e.sig), cyc, e.at, got, e.val);
                end
            end
        end
    end

    task automatic por_checks();
        // R4: state right after power-on reset
        expect_at(0, S_SEL, 1'b0, 4);
        expect_at(0, S_FP,  1'b0, 4);
        expect_at(0, S_DRV, 1'b1, 4);
        expect_at(0, S_CRS, 1'b0, 4);
        expect_at(RST - 1, S_DRV, 1'b1, 4);
        expect_at(RST, S_DRV, 1'b0, 4);
        expect_at(RST, S_CRS, 1'b1, 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_por_n = 1'b1;
        por_checks();

        // R1: run one short of the delay, no switch; R6 flag follows
        to_cyc(8);  coil_above_on = 1'b1;
        expect_at(9, S_FP, 1'b1, 6);
        expect_at(13, S_SEL, 1'b0, 1);
        to_cyc(13); coil_above_on = 1'b0;
        expect_at(14, S_SEL, 1'b0, 1);
        expect_at(14, S_FP, 1'b1, 6);   // R6 hold with both flags low
        to_cyc(14); coil_below_off = 1'b1;
        expect_at(15, S_FP, 1'b0, 6);
        to_cyc(15); coil_below_off = 1'b0;

        // R1: full run switches at the sixth qualifying edge
        to_cyc(16); coil_above_on = 1'b1;
        expect_at(17, S_FP, 1'b1, 6);
        expect_at(21, S_SEL, 1'b0, 1);
        expect_at(22, S_SEL, 1'b1, 1);
        expect_at(22, S_DRV, 1'b0, 3);

        // R2: short off run is ignored
        to_cyc(24); coil_above_on = 1'b0; coil_below_off = 1'b1;
        expect_at(25, S_FP, 1'b0, 6);
        expect_at(27, S_SEL, 1'b1, 2);
        to_cyc(27); coil_below_off = 1'b0;
        expect_at(28, S_SEL, 1'b1, 2);
        expect_at(28, S_DRV, 1'b0, 3);

        // R2 + R3: full off run, reset pulse of RST cycles
        to_cyc(30); coil_below_off = 1'b1;
        expect_at(33, S_SEL, 1'b1, 2);
        expect_at(34, S_SEL, 1'b0, 2);
        expect_at(34, S_DRV, 1'b1, 3);
        expect_at(34, S_CRS, 1'b0, 3);
        expect_at(38, S_DRV, 1'b1, 3);
        expect_at(39, S_DRV, 1'b0, 3);
        expect_at(39, S_CRS, 1'b1, 3);

        // R5: external reset
        to_cyc(40); coil_below_off = 1'b0; ext_rst_n = 1'b0;
        expect_at(41, S_CRS, 1'b0, 5);
        expect_at(41, S_DRV, 1'b0, 5);
        expect_at(42, S_CRS, 1'b0, 5);
        to_cyc(42); ext_rst_n = 1'b1;
        expect_at(43, S_CRS, 1'b1, 5);

        // R7: disable (11000111), field held long, stays on battery
        to_cyc(44); coil_above_on = 1'b1; cmd_valid = 1'b1; cmd_byte = 8'hC7;
        expect_at(45, S_FP, 1'b1, 6);
        expect_at(52, S_SEL, 1'b0, 7);
        expect_at(60, S_SEL, 1'b0, 7);
        to_cyc(45); cmd_valid = 1'b0;

        // R9: non-matching bytes do not re-enable
        to_cyc(60); cmd_valid = 1'b1; cmd_byte = 8'hCE;
        to_cyc(61); cmd_byte = 8'h0F;
        to_cyc(62); cmd_valid = 1'b0;
        expect_at(70, S_SEL, 1'b0, 9);

        // R8: enable (11111111), count starts the edge after
        to_cyc(72); cmd_valid = 1'b1; cmd_byte = 8'hFF;
        expect_at(78, S_SEL, 1'b0, 8);
        expect_at(79, S_SEL, 1'b1, 8);
        to_cyc(73); cmd_valid = 1'b0;

        // R7 + R3: disable (11100111) while on field
        to_cyc(82); cmd_valid = 1'b1; cmd_byte = 8'hE7;
        expect_at(83, S_SEL, 1'b0, 7);
        expect_at(83, S_DRV, 1'b1, 3);
        expect_at(87, S_DRV, 1'b1, 3);
        expect_at(88, S_DRV, 1'b0, 3);
        to_cyc(83); cmd_valid = 1'b0;

        // R9: external reset does not restore automatic mode
        to_cyc(90); ext_rst_n = 1'b0;
        expect_at(91, S_CRS, 1'b0, 5);
        to_cyc(91); ext_rst_n = 1'b1;
        expect_at(92, S_CRS, 1'b1, 5);
        expect_at(100, S_SEL, 1'b0, 9);

        to_cyc(101);
        while (sb_q.size() != 0) @(negedge clk);

        // R9 + R4: power-on reset restores automatic mode
        @(posedge clk);
        #5 rst_por_n = 1'b0;
        repeat (2) @(posedge clk);
        #5 rst_por_n = 1'b1;
        por_checks();
        expect_at(1, S_FP, 1'b1, 6);
        expect_at(5, S_SEL, 1'b0, 9);
        expect_at(6, S_SEL, 1'b1, 9);

        to_cyc(12);
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 scoreboard: got %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule